// File: doc/BRIEF.md
# Ethernet receive frame classifier

This block sits after a receive MAC and decides, for every incoming frame, whether the buffer writer keeps it or rolls it back. It works in a fixed order. When the destination address arrives, the address filter judges it. A frame that passes records an early event. At end of frame, acceptance rules based on frame status decide whether the frame is kept. The frame's status bits then go into a sticky event word, and the interrupt request is driven from the enabled event bits.

The address filter has five match modes, any of which can pass a frame: accept all, hash table lookup, any group address, exact match to the station address, and the all-ones broadcast address. A frame that fails the address filter is dropped silently and leaves no trace in the event word. A frame that passes the address filter but fails the acceptance rules is still dropped, but its status is recorded. The host reads the event word, and the read clears it.

Top module: `rx_frame_classifier`

## Requirements
- R1: After reset, keep_stb, drop_stb, irq and evt_data are all 0.
- R2: With addr_mode bit 0 (accept all) set, a frame passes the address filter whatever its destination.
- R3: With addr_mode bit 3 set, a frame passes when da equals my_addr exactly. With addr_mode bit 4 set, a frame passes when da is all ones. With addr_mode bit 2 set, a frame passes when da[0] (group bit of the first byte, which is da[7:0]) is 1.
- R4: With addr_mode bit 1 set, a frame passes when hash_tbl[idx] is 1. Here idx is bits 31:26 of a 32-bit register that starts at all ones, is shifted right once per address bit in the order da[0] to da[47], and is XORed with 32'hEDB88320 whenever its bit 0 differs from the incoming bit. No final inversion is applied.
- R5: A frame that passes no enabled address mode produces drop_stb at end of frame, and evt_data does not change.
- R6: One cycle after a da_valid whose address passes, evt_data bit 5 (early) is set.
- R7: A frame with none of the three error flags is kept only if accept_en bit 0 is set. A frame with error flags is kept only if every flag it carries is accepted: too long by bit 1, runt by bit 2, CRC error by bit 3.
- R8: For each eof_valid, exactly one of keep_stb or drop_stb pulses for a single cycle, one cycle later.
- R9: For every frame that passed the address filter, whether it is kept or not, the event word records its status: bit 0 for no error, bit 1 for too long, bit 2 for runt, bit 3 for CRC error.
- R10: dma_done sets evt_data bit 4 one cycle later.
- R11: irq is 1 exactly when some evt_data bit has its irq_en bit at the same position set. It stays 1 until the event word is read.
- R12: An evt_rd pulse clears the event word one cycle later. An event that arrives in the same cycle as the read is kept. Bits are never cleared without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_mode | input | 5 | Address match enables: 0 all, 1 hash, 2 group, 3 exact, 4 broadcast |
| my_addr | input | 48 | Station address for exact match |
| hash_tbl | input | 64 | Hash lookup table |
| accept_en | input | 4 | Accept enables: 0 good, 1 too long, 2 runt, 3 CRC error |
| irq_en | input | 6 | Interrupt enables, same bit positions as evt_data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first byte in bits 7:0 |
| eof_valid | input | 1 | End-of-frame strobe with status flags |
| eof_crc_err | input | 1 | Frame had a CRC error |
| eof_runt | input | 1 | Frame was shorter than 64 bytes |
| eof_long | input | 1 | Frame was longer than 1518 bytes |
| dma_done | input | 1 | Receive DMA completion pulse |
| evt_rd | input | 1 | Host read of the event word |
| keep_stb | output | 1 | Commit the current frame |
| drop_stb | output | 1 | Roll back the current frame |
| evt_data | output | 6 | Sticky event word |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches every cycle for these properties: the two strobes never assert together, and every strobe follows an end-of-frame. Event bits never clear without a read, and a read with no new event empties the word. A rising interrupt always has a cause: a new event or a change to the enable mask. Which frames each address mode passes, the hash index, the acceptance outcome for each combination of error flags, and the silence after a failed address are shown only by the bench's scenarios, which compare strobes and the event word against expected values.

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier #(
  parameter int ADDR_W = 48,
  parameter int HASH_BITS = 6,
  localparam int HASH_N = 1 << HASH_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        addr_mode,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic [HASH_N-1:0] hash_tbl,
  input  logic [3:0]        accept_en,
  input  logic [5:0]        irq_en,
  input  logic              da_valid,
  input  logic [ADDR_W-1:0] da,
  input  logic              eof_valid,
  input  logic              eof_crc_err,
  input  logic              eof_runt,
  input  logic              eof_long,
  input  logic              dma_done,
  input  logic              evt_rd,
  output logic              keep_stb,
  output logic              drop_stb,
  output logic [5:0]        evt_data,
  output logic              irq
);

  function automatic logic [HASH_BITS-1:0] hash_idx(input logic [ADDR_W-1:0] a);
    logic [31:0] c;
    c = '1;
    for (int i = 0; i < ADDR_W; i++)
      c = (c >> 1) ^ ((c[0] ^ a[i]) ? 32'hEDB88320 : 32'h0);
    return c[31:32-HASH_BITS];
  endfunction

  logic da_pass;
  logic addr_ok, good, acc_ok, frm;
  logic [5:0] evt_set;

  assign addr_ok = addr_mode[0]
                 | (addr_mode[1] & hash_tbl[hash_idx(da)])
                 | (addr_mode[2] & da[0])
                 | (addr_mode[3] & (da == my_addr))
                 | (addr_mode[4] & (&da));

  assign good   = ~(eof_crc_err | eof_runt | eof_long);
  assign acc_ok = good ? accept_en[0]
                       : ((~eof_long | accept_en[1]) & (~eof_runt | accept_en[2])
                          & (~eof_crc_err | accept_en[3]));
  assign frm    = eof_valid & da_pass;

  assign evt_set = {da_valid & addr_ok, dma_done, frm & eof_crc_err,
                    frm & eof_runt, frm & eof_long, frm & good};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      da_pass  <= 1'b0;
      keep_stb <= 1'b0;
      drop_stb <= 1'b0;
      evt_data <= '0;
    end else begin
      if (da_valid)       da_pass <= addr_ok;
      else if (eof_valid) da_pass <= 1'b0;
      keep_stb <= frm & acc_ok;
      drop_stb <= eof_valid & ~(da_pass & acc_ok);
      evt_data <= (evt_rd ? 6'd0 : evt_data) | evt_set;
    end
  end

  assign irq = |(evt_data & irq_en);

endmodule

module rx_frame_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       keep_stb,
  input logic       drop_stb,
  input logic       eof_valid,
  input logic       da_valid,
  input logic       dma_done,
  input logic       evt_rd,
  input logic       irq,
  input logic [5:0] irq_en,
  input logic [5:0] evt_data
);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(keep_stb && drop_stb));

  assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_stb || drop_stb) |-> $past(eof_valid));

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_rd |=> ((evt_data & $past(evt_data)) == $past(evt_data)));

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && !eof_valid && !da_valid && !dma_done) |=> (evt_data == 6'd0));

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(eof_valid || da_valid || dma_done) || !$stable(irq_en)));

endmodule

bind rx_frame_classifier rx_frame_classifier_chk u_chk (.*);

// File: tb/rx_frame_classifier_bench.sv
module rx_frame_classifier_bench;
  logic clk = 0, rst_n = 0;
  logic [4:0] addr_mode = 0;
  logic [47:0] my_addr = 48'h5544_3322_1100;
  logic [63:0] hash_tbl = 0;
  logic [3:0] accept_en = 0;
  logic [5:0] irq_en = 0;
  logic da_valid = 0, eof_valid = 0, eof_crc_err = 0, eof_runt = 0, eof_long = 0;
  logic dma_done = 0, evt_rd = 0;
  logic [47:0] da = 0;
  logic keep_stb, drop_stb, irq;
  logic [5:0] evt_data;
  int checks = 0, errs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_frame_classifier u_rx_frame_classifier (.*);

  typedef struct packed {
    logic [4:0] mode; logic [3:0] acc; logic [47:0] a; logic [2:0] fl;
    logic keep; logic drop; logic [5:0] evt;
  } vec_t;

  localparam vec_t VT [13] = '{
    '{5'b00001, 4'b0001, 48'h1234_5678_9ABC, 3'b000, 1'b1, 1'b0, 6'b100001}, // R2
    '{5'b01000, 4'b0001, 48'h5544_3322_1100, 3'b000, 1'b1, 1'b0, 6'b100001}, // R3
    '{5'b01000, 4'b0001, 48'h5544_3322_1000, 3'b000, 1'b0, 1'b1, 6'b000000}, // R5
    '{5'b10000, 4'b0001, 48'hFFFF_FFFF_FFFF, 3'b000, 1'b1, 1'b0, 6'b100001}, // R3
    '{5'b10000, 4'b0001, 48'h0000_0000_0001, 3'b000, 1'b0, 1'b1, 6'b000000}, // R5
    '{5'b00100, 4'b0001, 48'h0100_5E00_0001, 3'b000, 1'b1, 1'b0, 6'b100001}, // R3
    '{5'b01000, 4'b0001, 48'h5544_3322_1100, 3'b100, 1'b0, 1'b1, 6'b101000}, // R7 R9
    '{5'b01000, 4'b1001, 48'h5544_3322_1100, 3'b100, 1'b1, 1'b0, 6'b101000}, // R7
    '{5'b01000, 4'b0101, 48'h5544_3322_1100, 3'b010, 1'b1, 1'b0, 6'b100100}, // R7
    '{5'b01000, 4'b0010, 48'h5544_3322_1100, 3'b101, 1'b0, 1'b1, 6'b101010}, // R7 R9
    '{5'b01000, 4'b1010, 48'h5544_3322_1100, 3'b101, 1'b1, 1'b0, 6'b101010}, // R7
    '{5'b00000, 4'b1111, 48'h5544_3322_1100, 3'b000, 1'b0, 1'b1, 6'b000000}, // R5
    '{5'b01000, 4'b0000, 48'h5544_3322_1100, 3'b000, 1'b0, 1'b1, 6'b100001}  // R7 R9
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [47:0] a, input logic [2:0] f);
    @(negedge clk); da = a; da_valid = 1;
    @(negedge clk); da_valid = 0; eof_valid = 1; {eof_crc_err, eof_runt, eof_long} = f;
    @(negedge clk); eof_valid = 0; {eof_crc_err, eof_runt, eof_long} = 3'b000;
  endtask

  task automatic rd();
    @(negedge clk); evt_rd = 1;
    @(negedge clk); evt_rd = 0;
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] by = a[8*b +: 8];
      for (int k = 0; k < 8; k++) begin
        logic fb = r[0] ^ by[k];
        r = {1'b0, r[31:1]};
        if (fb) r = r ^ 32'hEDB88320;
      end
    end
    return r[31:26];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 keep", keep_stb, 0);
    check("R1 drop", drop_stb, 0);
    check("R1 irq", irq, 0);
    check("R1 evt", evt_data, 0);
    rst_n = 1;

    foreach (VT[i]) begin
      rd();
      addr_mode = VT[i].mode; accept_en = VT[i].acc;
      frame(VT[i].a, VT[i].fl);
      check("R8 keep", keep_stb, VT[i].keep);
      check("R8 drop", drop_stb, VT[i].drop);
      check("R9 evt", evt_data, VT[i].evt);
    end
    @(negedge clk);
    check("R8 one-cycle", {keep_stb, drop_stb}, 0);

    // R4 hash hit and miss
    rd();
    addr_mode = 5'b00010; accept_en = 4'b0001;
    hash_tbl = 64'd1 << ref_idx(48'h0000_0000_2200);
    frame(48'h0000_0000_2200, 3'b000);
    check("R4 hash hit", keep_stb, 1);
    hash_tbl = ~(64'd1 << ref_idx(48'h0000_0000_2200));
    frame(48'h0000_0000_2200, 3'b000);
    check("R4 hash miss", drop_stb, 1);

    // R6 early bit right after address
    rd();
    addr_mode = 5'b00001;
    @(negedge clk); da = 48'h0; da_valid = 1;
    @(negedge clk); da_valid = 0;
    check("R6 early", evt_data, 6'b100000);
    @(negedge clk); eof_valid = 1;
    @(negedge clk); eof_valid = 0;

    // R5 failed address leaves no event and no irq
    rd();
    irq_en = 6'b111111; addr_mode = 5'b01000;
    frame(48'h0000_0000_0200, 3'b000);
    check("R5 drop", drop_stb, 1);
    check("R5 evt", evt_data, 0);
    check("R5 irq", irq, 0);

    // R11 masking and hold
    irq_en = 6'b000001; accept_en = 4'b1111;
    frame(48'h5544_3322_1100, 3'b100);
    check("R11 masked", irq, 0);
    rd();
    frame(48'h5544_3322_1100, 3'b000);
    check("R11 raised", irq, 1);
    repeat (3) @(negedge clk);
    check("R11 held", irq, 1);
    rd();
    check("R12 cleared", evt_data, 0);
    check("R11 released", irq, 0);

    // R10 and R12 DMA event in the same cycle as a read
    irq_en = 6'b010000;
    @(negedge clk); dma_done = 1; evt_rd = 1;
    @(negedge clk); dma_done = 0; evt_rd = 0;
    check("R10 dma", evt_data, 6'b010000);
    check("R12 kept", irq, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule